// File: doc/BRIEF.md
# Reloadable Down-Counting Tick Timer

This block is a periodic timer built around a 24-bit down counter. Software programs a period into a reload register, selects the tick source and turns the counter on. From then on, the counter steps down by one per tick. When it steps from 1 to 0, it sets a sticky flag and can raise a single-cycle interrupt. On the tick that follows, it reloads, so an interrupt arrives every reload+1 ticks.

There are two tick sources. The first is every core clock cycle. The second is the rising edge of an external tick line, which the block synchronizes into the core clock domain. A small register port gives access to three words: control/status, reload and current value. The register port has no wait states. Read data is combinational from the address. The side effects of a read or a write take place at the clock edge that samples the request.

Top module: `tick_timer`

## Requirements
- R1: While the enable bit (control bit 0) is 1, the 24-bit current value decrements by one on every tick. While it is 0, the current value holds.
- R2: The count flag, read at control bit 16, is set at the edge where the current value steps from 1 to 0.
- R3: A tick taken while the current value is 0 loads the reload value (address 1, bits 23:0). A running counter therefore produces the 1-to-0 step once every reload+1 ticks.
- R4: The `irq` output is high for exactly one clock, after the edge of a 1-to-0 step. This happens only when the interrupt-enable bit (control bit 1) is 1.
- R5: A read of the control word (address 0) returns the flag and then clears it. A 1-to-0 step in the same cycle wins, and the flag stays set.
- R6: Any write to the current-value word (address 2) sets the count to 0 and clears the flag, whatever the data. It raises no interrupt, and it overrides a tick in the same cycle.
- R7: With a reload value of 0, the counter stays at 0 and the flag is never set.
- R8: Control bit 2 selects the tick source. A value of 1 selects every core clock. A value of 0 selects one tick per synchronized rising edge of `ext_tick`, so a level held high gives only one tick.
- R9: After reset, control reads 0x00000004 (core clock selected, everything else off), reload and current value read 0, and `irq` is low. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External tick line, asynchronous, counted on rising edges |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; the read side effect applies at the sampling edge |
| bus_addr | input | 2 | Word select: 0 control/status, 1 reload, 2 current value |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Single-cycle tick interrupt |

## Verification
The counter runs from the core clock for chosen numbers of ticks, ending at mid-count, at exactly 0 and past a reload. These runs separate a wrong decrement from a wrong reload point and an off-by-one period. Runs repeat with the interrupt enable cleared, with a reload of 0 and with a current-value write over a set flag. These show that flag, interrupt and counter are gated independently. External-source runs use long high pulses and a quiet line. They show that one tick is counted per edge and none is counted while the line is idle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int unsigned ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_CUR  = 2'd2;

    localparam int unsigned B_RUN  = 0;
    localparam int unsigned B_IE   = 1;
    localparam int unsigned B_SRC  = 2;
    localparam int unsigned B_FLAG = 16;

    typedef struct packed {
        logic run;
        logic ie;
        logic src;
        logic flag;
        logic irq;
    } ctl_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign st_d.chain[0] = async_in;
            end else begin : g_rest
                assign st_d.chain[i] = st_q.chain[i-1];
            end
        end
    endgenerate

    assign st_d.last = st_q.chain[STAGES-1];
    assign rise      = st_q.chain[STAGES-1] & ~st_q.last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/tick_count.sv
module tick_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                wrap     = (st_q.cnt == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - ONE));
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt));
    assert_zero_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && st_q.cnt == '0) |=> (st_q.cnt == '0));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
endmodule

// File: rtl/tick_csr.sv
module tick_csr
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_rise,
    input  logic              wrap,
    output logic              tick,
    output logic              clr,
    output logic [CNT_W-1:0]  reload,
    output ctl_t              ctl
);
    localparam ctl_t CTL_RST = '{run: 1'b0, ie: 1'b0, src: 1'b1, flag: 1'b0, irq: 1'b0};

    ctl_t             ctl_d, ctl_q;
    logic [CNT_W-1:0] load_d, load_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];
    assign tick = ctl_q.run & (ctl_q.src | ext_rise);
    assign clr  = wr && (addr == A_CUR);

    always_comb begin
        ctl_d     = ctl_q;
        load_d    = load_q;
        ctl_d.irq = wrap & ctl_q.ie;
        if (wr && addr == A_CTRL) begin
            ctl_d.run = wdata[B_RUN];
            ctl_d.ie  = wdata[B_IE];
            ctl_d.src = wdata[B_SRC];
        end
        if (wr && addr == A_LOAD) begin
            load_d = wdata[CNT_W-1:0];
        end
        if (clr) begin
            ctl_d.flag = 1'b0;
        end else if (wrap) begin
            ctl_d.flag = 1'b1;
        end else if (rd && addr == A_CTRL) begin
            ctl_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RST;
            load_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            load_q <= load_d;
        end
    end

    assign ctl    = ctl_q;
    assign reload = load_q;

    assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |-> ctl_q.flag);
    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |=> !ctl_q.irq);
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |-> $past(ctl_q.ie));
    assert_clr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ctl_q.flag && !ctl_q.irq));
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_CTRL && !wrap) |=> !ctl_q.flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 24,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             ext_rise, tick, clr, wrap;
    logic [CNT_W-1:0] reload, cnt;
    ctl_t             ctl;

    tick_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_tick), .rise(ext_rise)
    );

    tick_csr #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .ext_rise(ext_rise), .wrap(wrap), .tick(tick),
        .clr(clr), .reload(reload), .ctl(ctl)
    );

    tick_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .reload(reload),
        .cnt(cnt), .wrap(wrap)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_RUN]  = ctl.run;
                bus_rdata[B_IE]   = ctl.ie;
                bus_rdata[B_SRC]  = ctl.src;
                bus_rdata[B_FLAG] = ctl.flag;
            end
            A_LOAD:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload};
            A_CUR:   bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ctl.irq;

    assert_flag_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.flag) |-> (cnt == '0));
    assert_reload_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == '0) |=> (cnt == $past(reload)));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    irq_seen = 0;
    int    cyc = 0;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // monitor: pops expected read data and counts irq pulses
    always @(negedge clk) begin
        if (rst_n && irq) irq_seen++;
        if (bus_rd && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // one bus operation per clock, applied at the following edge
    task automatic op(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 2'd0, 32'd0);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_exp(input string tag, input logic [1:0] a, input logic [31:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        exp_q.push_back(it);
        op(1'b0, 1'b1, a, 32'd0);
    endtask

    task automatic chk_irq(input string tag, input int e);
        idle(1);
        n_chk++;
        if (irq_seen != e) begin
            n_bad++;
            $display("FAIL %s: got %0d irq pulses expected %0d", tag, irq_seen, e);
        end
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1; idle(4);
            ext_tick = 1'b0; idle(4);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset values
        n_chk++;
        if (irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 irq: got %b expected 0", irq);
        end
        rd_exp("R9 ctrl", 2'd0, 32'h4);
        rd_exp("R9 reload", 2'd1, 32'h0);
        rd_exp("R9 current", 2'd2, 32'h0);
        rd_exp("R9 addr3", 2'd3, 32'h0);

        // R1: run 4 core ticks from 0 with reload 5: 0->5->4->3->2
        wr_reg(2'd1, 32'hFF00_0005);
        rd_exp("R3 reload bits", 2'd1, 32'h5);
        wr_reg(2'd2, 32'h0);
        wr_reg(2'd0, 32'h7);
        idle(3);
        wr_reg(2'd0, 32'h6);
        rd_exp("R1 mid count", 2'd2, 32'h2);
        idle(3);
        rd_exp("R1 held while off", 2'd2, 32'h2);
        rd_exp("R2 no flag yet", 2'd0, 32'h6);

        // R2 R4: two ticks reach 0
        wr_reg(2'd0, 32'h7);
        idle(1);
        wr_reg(2'd0, 32'h6);
        rd_exp("R2 at zero", 2'd2, 32'h0);
        chk_irq("R4 first pulse", 1);
        rd_exp("R2 flag set", 2'd0, 32'h0001_0006);
        rd_exp("R5 flag cleared by read", 2'd0, 32'h6);

        // R3: six ticks = one full period 0->5..0
        wr_reg(2'd0, 32'h7);
        idle(5);
        wr_reg(2'd0, 32'h6);
        rd_exp("R3 period end", 2'd2, 32'h0);
        chk_irq("R3 one pulse per period", 2);
        rd_exp("R3 flag", 2'd0, 32'h0001_0006);

        // R4: interrupt enable off, flag still sets
        wr_reg(2'd0, 32'h5);
        idle(5);
        wr_reg(2'd0, 32'h4);
        chk_irq("R4 gated off", 2);
        rd_exp("R4 flag without irq", 2'd0, 32'h0001_0004);

        // R6: 8 ticks -> 4 with flag set, then write current
        wr_reg(2'd0, 32'h5);
        idle(7);
        wr_reg(2'd0, 32'h4);
        rd_exp("R3 after reload", 2'd2, 32'h4);
        wr_reg(2'd2, 32'h0000_0123);
        rd_exp("R6 count cleared", 2'd2, 32'h0);
        rd_exp("R6 flag cleared", 2'd0, 32'h4);
        chk_irq("R6 no irq", 2);

        // R7: reload 0 stays at 0
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'h7);
        idle(9);
        wr_reg(2'd0, 32'h6);
        rd_exp("R7 count", 2'd2, 32'h0);
        rd_exp("R7 no flag", 2'd0, 32'h6);
        chk_irq("R7 no irq", 2);

        // R8: external source
        wr_reg(2'd1, 32'h3);
        wr_reg(2'd0, 32'h3);
        idle(10);
        rd_exp("R8 quiet line", 2'd2, 32'h0);
        ext_pulses(2);
        rd_exp("R8 two edges", 2'd2, 32'h2);
        ext_pulses(2);
        rd_exp("R8 reached zero", 2'd2, 32'h0);
        chk_irq("R8 irq from ext", 3);
        rd_exp("R8 flag", 2'd0, 32'h0001_0003);
        wr_reg(2'd0, 32'h4);
        idle(3);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule